// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an external asynchronous 128K x 8 static RAM one byte at a time. The user side is a request/ready handshake that carries an address, write data and a write flag. Read data comes back with a single-cycle valid pulse. On the memory side the block drives a registered address, a low-true and a high-true chip select, an output enable and a write enable. The shared 8-bit data bus appears as separate outgoing data, a driver enable and incoming data, so the pad ring can build the three-state buffer.

Every bus phase lasts a whole number of clock cycles. The count is the memory's nanosecond limit divided by the clock period and rounded up, with a floor of one cycle. A parameter selects the fast (55 ns) or slow (70 ns) timing set. A retention input stops new accesses and holds the memory deselected, so it can drop to its low-voltage standby.

Top module: `sram_ctrl`

## Requirements
- R1: In reset and while idle, the active-low select is 1, the active-high select is 0, both enables are 1 and the data driver enable is 0. Ready is 1 in idle when retention is not requested.
- R2: The memory counts as selected only when the active-low select is 0 and the active-high select is 1. The two selects always change together.
- R3: A read keeps the memory selected with output enable 0 and write enable 1 for RD = max(ceil(tAA/Tclk), ceil(tOE/Tclk)) cycles (fast: 55/25 ns, slow: 70/35 ns). It samples the bus on the last of those cycles. Read-valid is a one-cycle pulse RD+1 cycles after the accepting edge and carries the sampled byte.
- R4: A write has one setup cycle, then a write-enable-low pulse of exactly WR = max(ceil(tWP), ceil(tAW), ceil(tDW)) cycles (fast: 40/45/20 ns, slow: 50/60/25 ns), then one recovery cycle. The memory is selected and the data drivers are on across all three. Output enable stays 1 for the whole write.
- R5: The data driver enable is 1 only during the three write phases. It is never 1 while output enable is 0.
- R6: When a read ends, the memory is deselected with drivers off for HZ = ceil(tHZ/Tclk) cycles (fast 20 ns, slow 25 ns) before the next access can start. The controller never drives the bus while the memory may still be driving it.
- R7: Each cycle count is ceil(ns*1000/CLK_PS), with a minimum of 1, computed at elaboration. At 8 ns in the fast grade this gives RD=7, WR=6 and HZ=3.
- R8: While retention is requested, ready is 0 and no request is accepted. Once any access in flight has finished, both selects stay inactive.
- R9: Ready is 1 only in idle. Address and write data are latched at acceptance, and the memory address does not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| ret_req | input | 1 | Retention/standby request |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W (8) | Read byte |
| mem_addr | output | ADDR_W (17) | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W (8) | Outgoing data to the bus |
| mem_dq_oe | output | 1 | Driver enable for the data bus |
| mem_dq_in | input | DATA_W (8) | Incoming data from the bus |

## Verification
The bench pairs the controller with a cycle-level memory model. The model returns a noise byte until the access window has elapsed, and keeps "driving" for the turnaround window after a read ends. A full write sweep followed by a read sweep over a reduced address space shows that every address and data bit lands in the right place. Reads that are sampled a cycle early return noise and so fail. Alternating read and write to the same address exercises the turnaround and shows any overlap of drivers. A retention request held against a pending request, and another raised in the middle of a read, separate "held off" from "aborted".

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_HZ,
        ST_WR_SU,
        ST_WR_PULSE,
        ST_WR_REC
    } bus_state_e;

    typedef struct packed {
        int rd_ns;
        int oe_ns;
        int wp_ns;
        int aw_ns;
        int dw_ns;
        int hz_ns;
    } grade_t;

    localparam grade_t GRADE_FAST = '{rd_ns: 55, oe_ns: 25, wp_ns: 40, aw_ns: 45, dw_ns: 20, hz_ns: 20};
    localparam grade_t GRADE_SLOW = '{rd_ns: 70, oe_ns: 35, wp_ns: 50, aw_ns: 60, dw_ns: 25, hz_ns: 25};

    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && done) |=> done);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= cap_en;
            if (cap_en)
                data <= din;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int CLK_PS     = 8000,
    parameter bit FAST_GRADE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ret_req,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam grade_t G      = FAST_GRADE ? GRADE_FAST : GRADE_SLOW;
    localparam int     RD_CYC = max2(ns_to_cyc(G.rd_ns, CLK_PS), ns_to_cyc(G.oe_ns, CLK_PS));
    localparam int     WR_CYC = max2(max2(ns_to_cyc(G.wp_ns, CLK_PS), ns_to_cyc(G.aw_ns, CLK_PS)),
                                     ns_to_cyc(G.dw_ns, CLK_PS));
    localparam int     HZ_CYC = ns_to_cyc(G.hz_ns, CLK_PS);
    localparam int     MAX_CYC = max2(max2(RD_CYC, WR_CYC), HZ_CYC);
    localparam int     CNT_W  = $clog2(MAX_CYC + 1);

    bus_state_e        state_q, state_d;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              phase_done;
    logic              cap_en;
    logic              accept;
    logic              sel;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready = (state_q == ST_IDLE) && !ret_req;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        cap_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                ld = 1'b1;
                if (req_write) begin
                    state_d = ST_WR_SU;
                end else begin
                    state_d = ST_RD;
                    ld_val  = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD: if (phase_done) begin
                cap_en  = 1'b1;
                state_d = ST_RD_HZ;
                ld      = 1'b1;
                ld_val  = CNT_W'(HZ_CYC - 1);
            end
            ST_RD_HZ: if (phase_done) state_d = ST_IDLE;
            ST_WR_SU: begin
                state_d = ST_WR_PULSE;
                ld      = 1'b1;
                ld_val  = CNT_W'(WR_CYC - 1);
            end
            ST_WR_PULSE: if (phase_done) state_d = ST_WR_REC;
            ST_WR_REC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .done     (phase_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .valid  (rsp_valid),
        .data   (rsp_rdata)
    );

    assign sel        = (state_q == ST_RD) || (state_q == ST_WR_SU) ||
                        (state_q == ST_WR_PULSE) || (state_q == ST_WR_REC);
    assign mem_cs_n   = !sel;
    assign mem_cs     = sel;
    assign mem_oe_n   = (state_q != ST_RD);
    assign mem_we_n   = (state_q != ST_WR_PULSE);
    assign mem_dq_oe  = (state_q == ST_WR_SU) || (state_q == ST_WR_PULSE) || (state_q == ST_WR_REC);
    assign mem_dq_out = wdata_q;
    assign mem_addr   = addr_q;

    // R5
    drv_vs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    // R3
    oe_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));
    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(!mem_cs_n)));
    // R9
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R8
    ret_block_chk: assert property (@(posedge clk) disable iff (rst)
        ret_req |-> !req_ready);
    // R6
    read_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (mem_cs_n && !mem_dq_oe));
endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CLK_NS = 8;
    localparam int ACC = (55 + CLK_NS - 1) / CLK_NS;
    localparam int WP_EXP = 6;
    localparam int DS_EXP = (20 + CLK_NS - 1) / CLK_NS;
    localparam int HZ = (20 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hA5;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    logic [DW-1:0] model_mem [256];

    always #4 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_NS*1000), .FAST_GRADE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ret_req(ret_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a << 1) ^ 8'h5A);
    endfunction
    function automatic logic [7:0] pat_b(input int a);
        return 8'(a * 6 + 2);
    endfunction

    // memory model: access window, hold-after-read window, write protocol
    int acc = 0, hz = 0, wlen = 0, dstab = 0;
    bit oebad = 0, abad = 0;
    logic [DW-1:0] wd;
    logic [AW-1:0] wa;
    always @(negedge clk) begin
        if (rst) begin
            acc = 0; hz = 0; wlen = 0; dstab = 0; oebad = 0; abad = 0;
            mem_dq_in = 8'hA5;
        end else begin
            logic msel, rd_act;
            msel   = !mem_cs_n && mem_cs;
            rd_act = msel && !mem_oe_n && mem_we_n;
            if (rd_act || hz > 0)
                check(!mem_dq_oe, "R6 bus contention", mem_dq_oe, 0);
            if (rd_act) begin
                acc++;
                hz = HZ;
                mem_dq_in = (acc >= ACC) ? model_mem[mem_addr] : 8'hA5;
            end else begin
                acc = 0;
                if (hz > 0) hz--;
                mem_dq_in = 8'hA5;
            end
            if (msel && !mem_we_n) begin
                if (wlen == 0) wa = mem_addr;
                else if (mem_addr != wa) abad = 1;
                wlen++;
                if (!mem_oe_n) oebad = 1;
                if (mem_dq_oe) begin
                    if (dstab > 0 && mem_dq_out == wd) dstab++;
                    else dstab = 1;
                    wd = mem_dq_out;
                end else dstab = 0;
            end else if (wlen > 0) begin
                check(wlen == WP_EXP, "R4 write pulse length", wlen, WP_EXP);
                check(dstab >= DS_EXP, "R4 data setup", dstab, DS_EXP);
                check(msel && mem_dq_oe && mem_dq_out == wd && mem_addr == wa,
                      "R4 recovery hold", {mem_dq_oe, mem_dq_out}, {1'b1, wd});
                check(!oebad && !abad, "R4 oe high / R9 addr stable", {oebad, abad}, 0);
                model_mem[wa] = wd;
                wlen = 0; dstab = 0; oebad = 0; abad = 0;
            end
        end
    end

    task automatic wait_ready();
        int guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R9 ready low while busy", req_ready, 0);
    endtask

    task automatic do_read(input int a, input logic [7:0] exp);
        int n = 0;
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 0;
        n = 1;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == ACC + 1, "R3 read latency", n, ACC + 1);
        check(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
        @(negedge clk);
        check(!rsp_valid, "R3 valid pulse width", rsp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 idle state
        check(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1 idle bus", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        check(req_ready && !rsp_valid, "R1 ready", {req_ready, rsp_valid}, 2'b10);

        // R4 R9 full write sweep, R3 R7 full read sweep
        for (int a = 0; a < 256; a++) do_write(a, pat_a(a));
        for (int a = 0; a < 256; a++) do_read(a, pat_a(a));

        // R6 write right after read on the same address
        for (int a = 0; a < 32; a++) begin
            do_read(a * 7 % 256, (a == 0) ? pat_a(0) : pat_a(a * 7 % 256));
            do_write(a * 7 % 256, pat_b(a));
            do_read(a * 7 % 256, pat_b(a));
        end

        // R8 retention holds off a pending request
        wait_ready();
        ret_req = 1; req_valid = 1; req_write = 1; req_addr = 8'd200; req_wdata = 8'h3C;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(!req_ready && mem_cs_n && !mem_cs, "R8 retention hold", {req_ready, mem_cs_n, mem_cs}, 3'b010);
        end
        check(model_mem[200] == pat_a(200), "R8 no write in retention", model_mem[200], pat_a(200));
        ret_req = 0;
        @(negedge clk);
        req_valid = 0;
        do_read(200, 8'h3C);

        // R8 retention raised mid-read: access completes, then stays deselected
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = 8'd17;
        @(negedge clk);
        req_valid = 0;
        ret_req = 1;
        begin
            int n = 1;
            while (!rsp_valid && n < 50) begin
                @(negedge clk);
                n++;
            end
            check(n == ACC + 1 && rsp_rdata == pat_a(17), "R8 in-flight read completes", rsp_rdata, pat_a(17));
        end
        repeat (HZ + 2) @(negedge clk);
        check(mem_cs_n && !mem_cs && !req_ready, "R8 deselected after access", {mem_cs_n, mem_cs, req_ready}, 3'b100);
        // R2 selects move together
        check(mem_cs_n != mem_cs, "R2 select pair", {mem_cs_n, mem_cs}, 2'b10);
        ret_req = 0;

        repeat (5) @(negedge clk);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule